// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives a serial bit clock from a fast system clock in three cascaded stages. A power-of-two prescaler comes first. Its select code either turns the clock off for minimum power or divides the input by 1, 2, 4, 8, 16, 32 or 64. An optional fixed divide-by-three stage follows the prescaler. The last stage is an optional shaper with two settings: one for the total period and one for the low time. Because these are set separately, the duty cycle of the serial clock is not tied to 50%.

Everything runs in the system clock domain. The block does not switch clocks. It produces a one-cycle `tick` each time the serial clock state may advance. It drives `sclk` as a registered level, and it raises one-cycle `rise` and `fall` strobes in the cycle where `sclk` changes, so that a shift register can act on them as clock enables. Any change to the configuration inputs restarts every counter. The serial clock then resumes at the start of a low phase.

Top module: `sclk_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `tick`, `sclk`, `rise` and `fall` are all 0.
- R2: With `src_sel` = 0 no `tick`, `rise` or `fall` is produced, and `sclk` holds at 0.
- R3: With `src_sel` = s in 1..7 and the divide-by-three stage off, `tick` pulses once every 2^(s-1) cycles. The first pulse comes 2^(s-1) cycles after a restart.
- R4: With `div3_en` = 1, the interval between ticks is three times the prescaler interval, counted from the restart.
- R5: With `prog_en` = 0, `sclk` inverts on every tick, starting from 0.
- R6: With `prog_en` = 1 and a legal setting (0 < `per_cfg`, `low_cfg` < `per_cfg`), every serial period lasts `per_cfg`+1 ticks. During it `sclk` is low for `low_cfg`+1 ticks and then high for the remaining ticks, starting with the low phase.
- R7: With `prog_en` = 1, a `per_cfg` of 0 acts as 1. A `low_cfg` at or above the effective period acts as the effective period minus one, so `sclk` still goes high once per period.
- R8: `rise` is high for one cycle exactly when `sclk` goes from 0 to 1, and `fall` exactly when it goes from 1 to 0. Both come together with `tick`, and the two are never high together.
- R9: In the cycle after any configuration input changes, `sclk` is 0 and no tick or strobe is given. All counting then resumes from zero under the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | SEL_W | 0 = off; s = divide by 2^(s-1) |
| div3_en | input | 1 | Insert the divide-by-three stage |
| prog_en | input | 1 | Use the period/low-time shaper |
| per_cfg | input | CNT_W | Total period in ticks minus one |
| low_cfg | input | CNT_W | Low time in ticks minus one |
| tick | output | 1 | One-cycle pulse per serial clock step |
| sclk | output | 1 | Serial clock level |
| rise | output | 1 | One-cycle strobe on an sclk rising edge |
| fall | output | 1 | One-cycle strobe on an sclk falling edge |

## Verification
The bench builds the block with its default widths: a 3-bit select and 8-bit period fields. This puts the whole select range within reach, including the divide-by-64 setting stacked with the divide-by-three stage. Short period settings keep the runs brief, while the clamp corners are still exercised: a zero period, a low time equal to the period, and a low time above it. Configurations change in the middle of a high phase and in the middle of a low phase, so the restart is seen from both clock levels.

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             div3_en,
  input  logic             prog_en,
  input  logic [CNT_W-1:0] per_cfg,
  input  logic [CNT_W-1:0] low_cfg,
  output logic             tick,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  localparam int PRE_W = (1 << SEL_W) - 2;
  localparam int CFG_W = SEL_W + 2 + 2 * CNT_W;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             restart;
  assign cfg_now = {src_sel, div3_en, prog_en, per_cfg, low_cfg};
  assign restart = cfg_now != cfg_q;

  always_ff @(posedge clk)
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;

  // power-of-two prescaler
  logic             src_on, pre_tick;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  assign src_on = src_sel != '0;
  always_comb pre_lim = src_on ? PRE_W'((1 << (int'(src_sel) - 1)) - 1) : '0;
  assign pre_tick = src_on && (pre_cnt == pre_lim);

  always_ff @(posedge clk)
    if (!rst_n || restart || !src_on) pre_cnt <= '0;
    else if (pre_tick)                pre_cnt <= '0;
    else                              pre_cnt <= pre_cnt + 1'b1;

  // divide-by-three stage
  logic [1:0] c3;
  logic       mid_tick;
  assign mid_tick = pre_tick && (!div3_en || c3 == 2'd2);

  always_ff @(posedge clk)
    if (!rst_n || restart)       c3 <= '0;
    else if (pre_tick && div3_en) c3 <= (c3 == 2'd2) ? 2'd0 : c3 + 2'd1;

  // period / low-time shaper
  logic [CNT_W-1:0] per_eff, low_eff, pc, pc_nx;
  logic             sclk_nx;
  assign per_eff = (per_cfg == '0) ? CNT_W'(1) : per_cfg;
  assign low_eff = (low_cfg >= per_eff) ? per_eff - 1'b1 : low_cfg;
  assign pc_nx   = (pc >= per_eff) ? '0 : pc + 1'b1;
  assign sclk_nx = prog_en ? (pc_nx > low_eff) : ~sclk;

  always_ff @(posedge clk)
    if (!rst_n || restart) begin
      pc   <= '0;
      sclk <= 1'b0;
      tick <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      tick <= mid_tick;
      rise <= mid_tick && !sclk && sclk_nx;
      fall <= mid_tick && sclk && !sclk_nx;
      if (mid_tick) begin
        sclk <= sclk_nx;
        if (prog_en) pc <= pc_nx;
      end
    end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
  p_rise_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (sclk && !$past(sclk) && tick));
  p_fall_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!sclk && $past(sclk) && tick));
  p_sclk_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sclk != $past(sclk)) && !$past(restart)) |-> tick);
  p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == '0) |=> (!tick && !rise));
  p_restart_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sclk && !tick && !fall));
endmodule

// File: tb/sim_sclk_gen.sv
module sim_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] src_sel;
  logic       div3_en, prog_en;
  logic [7:0] per_cfg, low_cfg;
  logic       tick, sclk, rise, fall;

  always #5 clk = ~clk;

  sclk_gen u0 (.clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div3_en(div3_en),
               .prog_en(prog_en), .per_cfg(per_cfg), .low_cfg(low_cfg),
               .tick(tick), .sclk(sclk), .rise(rise), .fall(fall));

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";

  // behavioural reference: cycles since restart -> expected outputs
  logic [20:0] m_cfg;
  int n, dv, k, te, le;
  logic m_tick, m_sclk, m_rise, m_fall, prev;

  task automatic chk(input string r, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", r, what, $time, act, exp);
    end
  endtask

  task automatic step();
    logic [20:0] cv;
    @(posedge clk);
    cv = {src_sel, div3_en, prog_en, per_cfg, low_cfg};
    if (!rst_n || cv != m_cfg) begin
      m_cfg = rst_n ? cv : 21'd0;
      n = 0;
      m_tick = 0; m_sclk = 0; m_rise = 0; m_fall = 0;
    end else begin
      n++;
      prev = m_sclk;
      dv = (src_sel == 0) ? 0 : (1 << (int'(src_sel) - 1)) * (div3_en ? 3 : 1);
      m_tick = (dv != 0) && (n % dv == 0);
      if (m_tick) begin
        k = n / dv;
        if (prog_en) begin
          te = (per_cfg == 0) ? 1 : int'(per_cfg);
          le = (int'(low_cfg) >= te) ? te - 1 : int'(low_cfg);
          m_sclk = (k % (te + 1)) > le;
        end else m_sclk = k[0];
      end
      m_rise = m_tick && !prev && m_sclk;
      m_fall = m_tick && prev && !m_sclk;
    end
    @(negedge clk);
    chk(req, "tick", int'(tick), int'(m_tick));
    chk(req, "sclk", int'(sclk), int'(m_sclk));
    chk("R8", "rise", int'(rise), int'(m_rise));
    chk("R8", "fall", int'(fall), int'(m_fall));
  endtask

  task automatic run(input string r, input int s, input bit d3, input bit pe,
                     input int per, input int low, input int cyc);
    req = r;
    src_sel = 3'(s); div3_en = d3; prog_en = pe;
    per_cfg = 8'(per); low_cfg = 8'(low);
    repeat (cyc) step();
  endtask

  initial begin
    m_cfg = 0; n = 0; m_tick = 0; m_sclk = 0; m_rise = 0; m_fall = 0;
    rst_n = 0; src_sel = 3'd1; div3_en = 0; prog_en = 0; per_cfg = 0; low_cfg = 0;
    repeat (3) step();                      // R1 reset state
    rst_n = 1;
    step();                                 // R1 first cycle after reset
    run("R2", 0, 0, 0, 5, 2, 40);           // R2 clock off
    for (int s = 1; s < 8; s++) run("R3", s, 0, 0, 0, 0, 200);
    run("R4", 2, 1, 0, 0, 0, 60);           // R4 divide by 6
    run("R4", 7, 1, 1, 3, 1, 1600);         // R4 divide by 192, shaped
    run("R5", 3, 0, 0, 9, 9, 80);           // R5 pass-through toggling
    run("R6", 1, 0, 1, 4, 1, 60);           // R6 low 2, high 3
    run("R6", 2, 0, 1, 5, 0, 80);           // R6 low 1, high 5
    run("R6", 1, 1, 1, 7, 5, 100);          // R6 with div3
    run("R7", 1, 0, 1, 3, 9, 40);           // R7 low above period
    run("R7", 1, 0, 1, 4, 4, 40);           // R7 low equal to period
    run("R7", 2, 0, 1, 0, 0, 40);           // R7 zero period
    run("R9", 1, 0, 1, 6, 1, 5);            // R9 stop inside high phase
    run("R9", 1, 0, 1, 6, 2, 30);
    run("R9", 1, 0, 1, 6, 2, 1);            // R9 stop inside low phase
    run("R9", 2, 0, 0, 6, 2, 30);
    run("R2", 0, 0, 0, 6, 2, 30);           // R2 off after activity
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule